// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Generator and Checker

This block runs the CRC-4 check over each E1 submultiframe, one bit per strobe. A submultiframe is eight frames of 256 bits, 2048 bits in all. The transmit and receive streams share one set of timing inputs: a bit-valid strobe, the frame offset inside the submultiframe (0 to 7), the bit position inside the frame (0 to 255) and a marker on the first bit of each submultiframe.

On the transmit side the block computes the remainder over the outgoing submultiframe. It writes that remainder into the four check-bit positions of the following submultiframe. On the receive side it computes the remainder over the incoming submultiframe and stores it. It then compares it with the check bits that arrive in the next submultiframe. Each mismatch gives an error pulse and steps a saturating counter.

Multiframe alignment is found elsewhere and arrives here as a level input.

Top module: `e1_crc4_smf`

## Requirements
- R1: Each remainder is the modulo-2 remainder of the submultiframe polynomial times x^4, divided by x^4 + x + 1. The first bit of the submultiframe is the highest-order term. Remainder bit C1 is the most significant and C4 the least significant.
- R2: The check bits sit at bit position 0 of frame offsets 0, 2, 4 and 6, carrying C1, C2, C3 and C4 in that order. Both directions treat these four positions as zero when dividing, whatever the stream carries there.
- R3: tx_out follows each valid bit by one clock, and tx_out_vld marks it. At a check-bit position tx_out carries the remainder of the previous transmit submultiframe, or zero before the first one completes. At every other position tx_out repeats tx_in.
- R4: When the last bit of a submultiframe arrives (offset 7, position 255), the four received check bits are compared with the stored receive remainder of the previous submultiframe. On any difference crc_err is high for exactly one clock, the cycle after that bit.
- R5: A comparison is made only when two conditions hold. The previous submultiframe and the current one must each have been received with mf_aligned high from their start marker through their last bit. Any valid bit with mf_aligned low cancels the pending comparison.
- R6: Cycles with bit_vld low change neither remainder, nor the captured check bits, nor the position state. tx_out_vld is low after such a cycle.
- R7: err_cnt steps by one on each crc_err pulse. It holds at all ones of its CNT_W-bit width, which is 16 by default.
- R8: Synchronous reset clears tx_out, tx_out_vld, crc_err, err_cnt and both stored remainders.
- R9: The running remainder restarts at each start marker. A corrupted data bit in one submultiframe therefore affects only the comparison made at the end of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Bit strobe for both streams |
| smf_start | input | 1 | First bit of a submultiframe |
| smf_frame | input | 3 | Frame offset inside the submultiframe |
| bit_pos | input | 8 | Bit position inside the frame |
| mf_aligned | input | 1 | Multiframe alignment held |
| tx_in | input | 1 | Outgoing bit before insertion |
| rx_in | input | 1 | Incoming bit |
| tx_out | output | 1 | Outgoing bit with check bits inserted |
| tx_out_vld | output | 1 | tx_out carries a bit |
| crc_err | output | 1 | One-clock mismatch pulse |
| err_cnt | output | CNT_W | Saturating mismatch count |

## Verification
The receive stream is the bench's own model of the transmit output. A clean run therefore has to agree with the transmit insertion, and the bench corrupts the received copy in chosen places.

- A flipped data bit must raise the error one submultiframe later, and only once. This separates a carried-over remainder from a fresh one.
- A flipped check bit must raise the error in the same submultiframe. This separates check-bit capture from the division.

Further runs cover the following:
- random, all-ones and all-zero payloads, with arbitrary values placed in the check-bit slots;
- strobe gaps;
- never-aligned and late-aligned submultiframes, carrying flips that must go unreported;
- a counter narrowed to two bits, so that saturation is reached.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;
  localparam int CRC_W     = 4;
  localparam int CRC_IDX_W = $clog2(CRC_W);
  // x^4 + x + 1 without the leading term
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  // one serial division step, message bit enters at the top
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r, input logic b);
    logic fb;
    fb = r[CRC_W-1] ^ b;
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/e1_smf_timing.sv
module e1_smf_timing
  import e1_crc4_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SMF_FRAMES = 8,
  parameter int POS_W      = $clog2(FRAME_BITS),
  parameter int OFS_W      = $clog2(SMF_FRAMES)
) (
  input  logic [OFS_W-1:0]     frame,
  input  logic [POS_W-1:0]     pos,
  output logic                 last,
  output logic                 slot,
  output logic [CRC_IDX_W-1:0] slot_idx
);
  logic [OFS_W-1:0] pair;

  always_comb begin
    pair     = frame >> 1;
    last     = (int'(frame) == SMF_FRAMES - 1) && (int'(pos) == FRAME_BITS - 1);
    slot     = (pos == '0) && !frame[0] && (int'(pair) < CRC_W);
    slot_idx = CRC_IDX_W'(pair);
  end
endmodule

// File: rtl/crc4_engine.sv
module crc4_engine
  import e1_crc4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             first,
  input  logic             last,
  input  logic             din,
  output logic [CRC_W-1:0] rem_q
);
  logic [CRC_W-1:0] run_q;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] nxt;

  always_comb begin
    base = first ? '0 : run_q;
    nxt  = crc_step(base, din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      rem_q <= '0;
    end else if (vld) begin
      run_q <= nxt;
      if (last) rem_q <= nxt;
    end
  end

  // R1
  rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(vld && last) |=> $stable(rem_q));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(run_q));
endmodule

// File: rtl/e1_crc_tx_insert.sv
module e1_crc_tx_insert
  import e1_crc4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld,
  input  logic                 slot,
  input  logic [CRC_IDX_W-1:0] slot_idx,
  input  logic                 tx_in,
  input  logic [CRC_W-1:0]     crc_rem,
  output logic                 tx_out,
  output logic                 tx_out_vld
);
  logic [CRC_IDX_W-1:0] sel;

  always_comb sel = CRC_IDX_W'(CRC_W - 1) - slot_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out     <= 1'b0;
      tx_out_vld <= 1'b0;
    end else begin
      tx_out_vld <= vld;
      if (vld) tx_out <= slot ? crc_rem[sel] : tx_in;
    end
  end

  // R3
  tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && !slot) |=> tx_out == $past(tx_in));

  // R6
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> !tx_out_vld);
endmodule

// File: rtl/e1_crc_rx_check.sv
module e1_crc_rx_check
  import e1_crc4_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld,
  input  logic                 first,
  input  logic                 last,
  input  logic                 slot,
  input  logic [CRC_IDX_W-1:0] slot_idx,
  input  logic                 aligned,
  input  logic                 rx_in,
  input  logic [CRC_W-1:0]     rem_q,
  output logic                 crc_err,
  output logic [CNT_W-1:0]     err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CRC_W-1:0]     cap_q;
  logic                 full_q;
  logic                 valid_q;
  logic                 full_now;
  logic [CRC_IDX_W-1:0] sel;

  always_comb begin
    full_now = first | full_q;
    sel      = CRC_IDX_W'(CRC_W - 1) - slot_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      full_q  <= 1'b0;
      valid_q <= 1'b0;
      crc_err <= 1'b0;
      err_cnt <= '0;
    end else begin
      crc_err <= 1'b0;
      if (vld) begin
        if (slot) cap_q[sel] <= rx_in;
        if (!aligned) begin
          full_q  <= 1'b0;
          valid_q <= 1'b0;
        end else begin
          if (first) full_q <= 1'b1;
          if (last) begin
            valid_q <= full_now;
            if (valid_q && full_now && (cap_q != rem_q)) begin
              crc_err <= 1'b1;
              if (err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
            end
          end
        end
      end
    end
  end

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |=> !crc_err);

  // R5
  err_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> $past(aligned) && $past(vld));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != $past(err_cnt)) |-> crc_err);
endmodule

// File: rtl/e1_crc4_smf.sv
module e1_crc4_smf
  import e1_crc4_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SMF_FRAMES = 8,
  parameter int CNT_W      = 16,
  parameter int POS_W      = $clog2(FRAME_BITS),
  parameter int OFS_W      = $clog2(SMF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             smf_start,
  input  logic [OFS_W-1:0] smf_frame,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             mf_aligned,
  input  logic             tx_in,
  input  logic             rx_in,
  output logic             tx_out,
  output logic             tx_out_vld,
  output logic             crc_err,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int N_DIR = 2;  // 0 transmit, 1 receive

  logic                 last;
  logic                 slot;
  logic [CRC_IDX_W-1:0] slot_idx;
  logic [N_DIR-1:0]     raw_bit;
  logic [N_DIR-1:0]     div_bit;
  logic [CRC_W-1:0]     rem [N_DIR];

  e1_smf_timing #(
    .FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES), .POS_W(POS_W), .OFS_W(OFS_W)
  ) u_timing (
    .frame(smf_frame), .pos(bit_pos), .last(last), .slot(slot), .slot_idx(slot_idx)
  );

  assign raw_bit = {rx_in, tx_in};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign div_bit[d] = slot ? 1'b0 : raw_bit[d];
    crc4_engine u_eng (
      .clk(clk), .rst(rst), .vld(bit_vld), .first(smf_start), .last(last),
      .din(div_bit[d]), .rem_q(rem[d])
    );
  end

  e1_crc_tx_insert u_tx (
    .clk(clk), .rst(rst), .vld(bit_vld), .slot(slot), .slot_idx(slot_idx),
    .tx_in(tx_in), .crc_rem(rem[0]), .tx_out(tx_out), .tx_out_vld(tx_out_vld)
  );

  e1_crc_rx_check #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .vld(bit_vld), .first(smf_start), .last(last),
    .slot(slot), .slot_idx(slot_idx), .aligned(mf_aligned), .rx_in(rx_in),
    .rem_q(rem[1]), .crc_err(crc_err), .err_cnt(err_cnt)
  );

  // R2
  start_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && smf_start) |-> (smf_frame == '0) && (bit_pos == '0));
endmodule

// File: tb/tb_e1_crc4_smf.sv
module tb_e1_crc4_smf;
  localparam int FB = 256;
  localparam int NF = 8;
  localparam int SMF_BITS = FB * NF;
  localparam int CW = 2;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, smf_start = 1'b0, mf_aligned = 1'b0, tx_in = 1'b0, rx_in = 1'b0;
  logic [2:0] smf_frame = '0;
  logic [7:0] bit_pos = '0;
  logic tx_out, tx_out_vld, crc_err;
  logic [CW-1:0] err_cnt;

  always #10 clk = ~clk;  // 50 MHz

  e1_crc4_smf #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .smf_start(smf_start), .smf_frame(smf_frame),
    .bit_pos(bit_pos), .mf_aligned(mf_aligned), .tx_in(tx_in), .rx_in(rx_in),
    .tx_out(tx_out), .tx_out_vld(tx_out_vld), .crc_err(crc_err), .err_cnt(err_cnt)
  );

  typedef struct {
    bit vld;
    bit slot;
    bit tx;
    bit err;
    int cnt;
  } item_t;

  item_t q[$];
  int vectors = 0;
  int miscompares = 0;

  bit pay [SMF_BITS];
  bit txo [SMF_BITS];
  bit rxb [SMF_BITS];
  logic [3:0] tx_prev = '0;
  logic [3:0] rx_prev = '0;
  bit rx_valid = 0;
  int model_cnt = 0;

  function automatic bit is_slot(input int i);
    return (i % FB == 0) && (((i / FB) % 2) == 0);
  endfunction

  function automatic int slot_k(input int i);
    return (i / FB) / 2;
  endfunction

  // long division by 10011 over the masked block followed by four zeros (R1, R2)
  function automatic logic [3:0] ref_crc(input bit m [SMF_BITS]);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      bit b;
      b = (i < SMF_BITS && !is_slot(i)) ? m[i] : 1'b0;
      r = {r[3:0], b};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  task automatic drive(input bit v, input bit st, input int idx, input bit al,
                       input bit ti, input bit ri, input item_t it);
    @(negedge clk);
    bit_vld    = v;
    smf_start  = st;
    smf_frame  = 3'(idx / FB);
    bit_pos    = 8'(idx % FB);
    mf_aligned = al;
    tx_in      = ti;
    rx_in      = ri;
    q.push_back(it);
  endtask

  // pat: 0 random, 1 all ones, 2 all zeros; flip: rx bit index to invert or -1
  task automatic run_smf(input int pat, input int align_from, input int flip, input int gap_every);
    logic [3:0] new_tx, new_rx, cap;
    bit full, exp_err;
    item_t it;
    for (int i = 0; i < SMF_BITS; i++)
      pay[i] = (pat == 0) ? bit'($urandom % 2) : (pat == 1);
    new_tx = ref_crc(pay);
    for (int i = 0; i < SMF_BITS; i++) begin
      txo[i] = is_slot(i) ? tx_prev[3 - slot_k(i)] : pay[i];
      rxb[i] = txo[i];
    end
    if (flip >= 0) rxb[flip] = ~rxb[flip];
    for (int k = 0; k < 4; k++) cap[3 - k] = rxb[k * 2 * FB];
    new_rx  = ref_crc(rxb);
    full    = (align_from == 0);
    exp_err = full && rx_valid && (cap != rx_prev);
    for (int i = 0; i < SMF_BITS; i++) begin
      bit al;
      al = (i >= align_from);
      if (gap_every > 0 && (i % gap_every) == 1) begin
        it = '{vld: 0, slot: 0, tx: 0, err: 0, cnt: model_cnt};
        drive(1'b0, bit'($urandom % 2), int'($urandom % SMF_BITS), al,
              bit'($urandom % 2), bit'($urandom % 2), it);
      end
      if (i == SMF_BITS - 1 && exp_err && model_cnt < CMAX) model_cnt++;
      it = '{vld: 1, slot: is_slot(i), tx: txo[i],
             err: (i == SMF_BITS - 1) ? exp_err : 1'b0, cnt: model_cnt};
      drive(1'b1, i == 0, i, al, pay[i], rxb[i], it);
    end
    tx_prev  = new_tx;
    rx_prev  = new_rx;
    rx_valid = full;
  endtask

  // monitor: pops one expected item per driven cycle
  initial begin
    item_t it;
    bit bad;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it  = q.pop_front();
        bad = 0;
        vectors++;
        if (tx_out_vld !== it.vld) begin
          bad = 1;
          $display("FAIL R6 tx_out_vld actual %0b expected %0b", tx_out_vld, it.vld);
        end else if (it.vld && tx_out !== it.tx) begin
          bad = 1;
          if (it.slot) $display("FAIL R1 R2 R3 check bit actual %0b expected %0b", tx_out, it.tx);
          else         $display("FAIL R3 data bit actual %0b expected %0b", tx_out, it.tx);
        end
        if (crc_err !== it.err) begin
          bad = 1;
          $display("FAIL R4 R5 R9 crc_err actual %0b expected %0b", crc_err, it.err);
        end
        if (int'(err_cnt) != it.cnt) begin
          bad = 1;
          $display("FAIL R7 err_cnt actual %0d expected %0d", err_cnt, it.cnt);
        end
        if (bad) miscompares++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    item_t it;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    vectors++;
    if (tx_out !== 1'b0 || tx_out_vld !== 1'b0 || crc_err !== 1'b0 || err_cnt !== '0) begin
      miscompares++;
      $display("FAIL R8 reset outputs actual %0b%0b%0b%0d expected 0000",
               tx_out, tx_out_vld, crc_err, err_cnt);
    end
    rst = 1'b0;
    run_smf(0, 0, -1, 0);          // first block: zeros inserted, no compare (R3, R5)
    run_smf(0, 0, -1, 0);          // clean compare (R4)
    run_smf(1, 0, -1, 7);          // all ones with strobe gaps (R6)
    run_smf(0, 0, 1000, 0);        // data flip, reported one block later (R9)
    run_smf(0, 0, -1, 0);          // error expected here
    run_smf(2, 0, -1, 0);          // all zeros, no repeat of the error (R9)
    run_smf(0, 0, 2 * FB, 0);      // C2 flip, error in the same block (R2, R4)
    run_smf(0, SMF_BITS, 0, 0);    // never aligned, flip ignored (R5)
    run_smf(0, 300, 4 * FB, 0);    // late alignment, flip ignored (R5)
    run_smf(0, 0, 6 * FB, 5);      // full, but previous not full: flip ignored (R5)
    run_smf(0, 0, -1, 0);          // clean compare after masked slot flip (R2)
    run_smf(0, 0, 0, 0);           // C1 flip, error
    run_smf(1, 0, 6 * FB, 0);      // C4 flip, error, counter saturates (R7)
    run_smf(0, 0, -1, 3);          // clean with gaps
    for (int n = 0; n < 4; n++) begin
      it = '{vld: 0, slot: 0, tx: 0, err: 0, cnt: model_cnt};
      drive(1'b0, 1'b0, 0, 1'b1, 1'b0, 1'b0, it);
    end
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule